// File: doc/BRIEF.md
# Weighted-Opcode 64-bit Integer ALU

This block is the integer execution unit of a virtual CPU that runs randomly generated programs. Each issued instruction carries an 8-bit opcode and two 64-bit operands, A and B. The opcode space is cut into contiguous ranges, so that frequent operations own wide ranges and rare ones own narrow ranges. Every opcode in a range selects the same function.

The unit covers wrapping add and subtract, low and high multiplies, bitwise logic, shifts and rotates. Several of these come in a 32-bit form that works on the low halves only. The two divide opcodes are not computed here. They raise a request flag for a separate divider and pass A through. Opcodes above the integer range pass A through and raise a flag saying that the instruction was not for this unit.

The result and both flags are registered. A valid result appears exactly one clock after a valid issue, and a new instruction may be issued on every cycle.

Top module: `wop_alu`

## Requirements
- R1: Opcode map, by inclusive decimal range:
  - 0–13 add64, 14–20 add32, 21–34 sub64, 35–41 sub32.
  - 42–45 mul64, 46–49 unsigned mulhigh64, 50–53 unsigned mul32, 54–57 signed mul32, 58–61 signed mulhigh64.
  - 62 unsigned div, 63 signed div.
  - 64–76 and64, 77–82 and32, 83–95 or64, 96–101 or32, 102–115 xor64, 116–121 xor32.
  - 122–128 shl, 129–132 shr, 133–135 sar, 136–146 rol, 147–157 ror.
  - 158–255 are not integer opcodes.
- R2: `out_valid` is high in the cycle after `in_valid` was high at a rising edge, and low otherwise.
- R3: add64 and sub64 return A+B and A−B modulo 2^64.
- R4: add32, sub32, and32, or32 and xor32 use only bits 31:0 of A and B. Result bits 31:0 hold the 32-bit wrapped outcome, and bits 63:32 are zero.
- R5: and64, or64 and xor64 return the bitwise outcome over all 64 bits.
- R6: mul64 returns the low 64 bits of A×B. The two mul32 forms return the full 64-bit product of bits 31:0 of A and B. The unsigned form treats those halves as unsigned values, and the signed form treats them as two's complement values.
- R7: The two mulhigh64 forms return bits 127:64 of the 128-bit product of A and B. The unsigned form treats both operands as unsigned, and the signed form treats both as two's complement.
- R8: Shifts and rotates use B[5:0] as the count and ignore the other bits of B. shl and shr fill vacated bits with zero. sar fills them with A[63]. A count of 0 returns A.
- R9: rol and ror rotate A left or right by B[5:0] bit positions.
- R10: Opcodes 62 and 63 return C = A, set `div_req` and clear `not_alu`.
- R11: Opcodes 158–255 return C = A, set `not_alu` and clear `div_req`. All other opcodes clear both flags.
- R12: After reset `out_valid`, `result`, `not_alu` and `div_req` are zero. In a cycle after one with `in_valid` low, `result` keeps its previous value and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the instruction on the inputs |
| opcode | input | 8 | Instruction opcode |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one clock after issue |
| result | output | 64 | Result C |
| not_alu | output | 1 | Issued opcode was outside the integer range |
| div_req | output | 1 | Issued opcode was a divide, for a separate unit |

## Verification
The overlap that matters is a new issue being decoded in the same cycle as the previous instruction's result is presented. This happens when `in_valid` stays high across unrelated opcode classes: a multiply followed by a divide pass-through, then an out-of-range opcode, then a shift. The bench streams such a run with no idle cycle between issues and compares every cycle's result and flags against a reference computed from the requirements. A stale flag or a late result would show up as a mismatch on the neighbouring instruction. A gap of idle cycles afterwards confirms that the result holds and that both flags drop.

// File: rtl/wop_alu.sv
module wop_alu #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         not_alu,
  output logic         div_req
);
  localparam int HW = W / 2;
  localparam int SW = $clog2(W);

  localparam logic [7:0] END_ADD    = 8'd13;
  localparam logic [7:0] END_ADD32  = 8'd20;
  localparam logic [7:0] END_SUB    = 8'd34;
  localparam logic [7:0] END_SUB32  = 8'd41;
  localparam logic [7:0] END_MUL    = 8'd45;
  localparam logic [7:0] END_MULHU  = 8'd49;
  localparam logic [7:0] END_MUL32U = 8'd53;
  localparam logic [7:0] END_MUL32S = 8'd57;
  localparam logic [7:0] END_MULHS  = 8'd61;
  localparam logic [7:0] END_DIV    = 8'd63;
  localparam logic [7:0] END_AND    = 8'd76;
  localparam logic [7:0] END_AND32  = 8'd82;
  localparam logic [7:0] END_OR     = 8'd95;
  localparam logic [7:0] END_OR32   = 8'd101;
  localparam logic [7:0] END_XOR    = 8'd115;
  localparam logic [7:0] END_XOR32  = 8'd121;
  localparam logic [7:0] END_SHL    = 8'd128;
  localparam logic [7:0] END_SHR    = 8'd132;
  localparam logic [7:0] END_SAR    = 8'd135;
  localparam logic [7:0] END_ROL    = 8'd146;
  localparam logic [7:0] END_ROR    = 8'd157;

  typedef enum logic [4:0] {
    K_ADD, K_ADD32, K_SUB, K_SUB32, K_MUL, K_MULHU, K_MUL32U, K_MUL32S,
    K_MULHS, K_DIV, K_AND, K_AND32, K_OR, K_OR32, K_XOR, K_XOR32,
    K_SHL, K_SHR, K_SAR, K_ROL, K_ROR, K_NONE
  } kind_t;

  kind_t kind;

  always_comb begin
    if      (opcode <= END_ADD)    kind = K_ADD;
    else if (opcode <= END_ADD32)  kind = K_ADD32;
    else if (opcode <= END_SUB)    kind = K_SUB;
    else if (opcode <= END_SUB32)  kind = K_SUB32;
    else if (opcode <= END_MUL)    kind = K_MUL;
    else if (opcode <= END_MULHU)  kind = K_MULHU;
    else if (opcode <= END_MUL32U) kind = K_MUL32U;
    else if (opcode <= END_MUL32S) kind = K_MUL32S;
    else if (opcode <= END_MULHS)  kind = K_MULHS;
    else if (opcode <= END_DIV)    kind = K_DIV;
    else if (opcode <= END_AND)    kind = K_AND;
    else if (opcode <= END_AND32)  kind = K_AND32;
    else if (opcode <= END_OR)     kind = K_OR;
    else if (opcode <= END_OR32)   kind = K_OR32;
    else if (opcode <= END_XOR)    kind = K_XOR;
    else if (opcode <= END_XOR32)  kind = K_XOR32;
    else if (opcode <= END_SHL)    kind = K_SHL;
    else if (opcode <= END_SHR)    kind = K_SHR;
    else if (opcode <= END_SAR)    kind = K_SAR;
    else if (opcode <= END_ROL)    kind = K_ROL;
    else if (opcode <= END_ROR)    kind = K_ROR;
    else                           kind = K_NONE;
  end

  // low-half operands and 32-bit results
  logic [HW-1:0] a_lo, b_lo;
  logic [HW-1:0] add32, sub32;
  assign a_lo  = op_a[HW-1:0];
  assign b_lo  = op_b[HW-1:0];
  assign add32 = a_lo + b_lo;
  assign sub32 = a_lo - b_lo;

  // one shared multiplier; 32-bit forms enter extended, signed high is corrected
  logic [W-1:0]   mul_a, mul_b;
  logic [2*W-1:0] prod;
  logic [W-1:0]   hi_u, hi_s;

  always_comb begin
    mul_a = op_a;
    mul_b = op_b;
    if (kind == K_MUL32U) begin
      mul_a = {{HW{1'b0}}, a_lo};
      mul_b = {{HW{1'b0}}, b_lo};
    end else if (kind == K_MUL32S) begin
      mul_a = {{HW{a_lo[HW-1]}}, a_lo};
      mul_b = {{HW{b_lo[HW-1]}}, b_lo};
    end
  end

  assign prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};
  assign hi_u = prod[2*W-1:W];
  assign hi_s = hi_u - (op_a[W-1] ? op_b : '0) - (op_b[W-1] ? op_a : '0);

  // shifts and rotates
  logic [SW-1:0]  shamt;
  logic [2*W-1:0] rot_l, rot_r;
  logic [W-1:0]   sar_v;
  assign shamt = op_b[SW-1:0];
  assign rot_l = {op_a, op_a} << shamt;
  assign rot_r = {op_a, op_a} >> shamt;
  assign sar_v = W'($signed(op_a) >>> shamt);

  logic [W-1:0] c_next;

  always_comb begin
    unique case (kind)
      K_ADD:    c_next = op_a + op_b;
      K_ADD32:  c_next = {{HW{1'b0}}, add32};
      K_SUB:    c_next = op_a - op_b;
      K_SUB32:  c_next = {{HW{1'b0}}, sub32};
      K_MUL,
      K_MUL32U,
      K_MUL32S: c_next = prod[W-1:0];
      K_MULHU:  c_next = hi_u;
      K_MULHS:  c_next = hi_s;
      K_AND:    c_next = op_a & op_b;
      K_AND32:  c_next = {{HW{1'b0}}, a_lo & b_lo};
      K_OR:     c_next = op_a | op_b;
      K_OR32:   c_next = {{HW{1'b0}}, a_lo | b_lo};
      K_XOR:    c_next = op_a ^ op_b;
      K_XOR32:  c_next = {{HW{1'b0}}, a_lo ^ b_lo};
      K_SHL:    c_next = op_a << shamt;
      K_SHR:    c_next = op_a >> shamt;
      K_SAR:    c_next = sar_v;
      K_ROL:    c_next = rot_l[2*W-1:W];
      K_ROR:    c_next = rot_r[W-1:0];
      default:  c_next = op_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      not_alu   <= 1'b0;
      div_req   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      not_alu   <= in_valid && (kind == K_NONE);
      div_req   <= in_valid && (kind == K_DIV);
      if (in_valid) result <= c_next;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !not_alu && !div_req && $stable(result)));
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(not_alu && div_req));
  assert_div_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 8'd62 || opcode == 8'd63)) |=> (div_req && result == $past(op_a)));
  assert_foreign_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > END_ROR) |=> (not_alu && result == $past(op_a)));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((opcode > END_ADD && opcode <= END_ADD32) ||
                  (opcode > END_SUB && opcode <= END_SUB32) ||
                  (opcode > END_AND && opcode <= END_AND32) ||
                  (opcode > END_OR  && opcode <= END_OR32)  ||
                  (opcode > END_XOR && opcode <= END_XOR32)))
    |=> (result[W-1:HW] == '0));
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > END_XOR32 && opcode <= END_ROR && op_b[SW-1:0] == '0)
    |=> (result == $past(op_a)));
endmodule

// File: tb/wop_alu_bench.sv
`timescale 1ns/1ps
module wop_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        out_valid, not_alu, div_req;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wop_alu u_wop_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
    .not_alu(not_alu), .div_req(div_req)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // reference for streamed checks, written from the requirement table
  function automatic logic [63:0] ref_c(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    logic [5:0] s;
    s = b[5:0];
    if (op <= 13) return a + b;
    if (op <= 20) return {32'd0, a[31:0] + b[31:0]};
    if (op <= 34) return a - b;
    if (op <= 41) return {32'd0, a[31:0] - b[31:0]};
    if (op <= 45) return a * b;
    if (op <= 49) begin p = {64'd0, a} * {64'd0, b}; return p[127:64]; end
    if (op <= 53) return {32'd0, a[31:0]} * {32'd0, b[31:0]};
    if (op <= 57) return 64'($signed(a[31:0]) * $signed(b[31:0]));
    if (op <= 61) begin p = 128'($signed(a) * $signed(b)); return p[127:64]; end
    if (op <= 63) return a;
    if (op <= 76) return a & b;
    if (op <= 82) return {32'd0, a[31:0] & b[31:0]};
    if (op <= 95) return a | b;
    if (op <= 101) return {32'd0, a[31:0] | b[31:0]};
    if (op <= 115) return a ^ b;
    if (op <= 121) return {32'd0, a[31:0] ^ b[31:0]};
    if (op <= 128) return a << s;
    if (op <= 132) return a >> s;
    if (op <= 135) return 64'($signed(a) >>> s);
    if (op <= 146) return (s == 0) ? a : ((a << s) | (a >> (7'd64 - {1'b0, s})));
    if (op <= 157) return (s == 0) ? a : ((a >> s) | (a << (7'd64 - {1'b0, s})));
    return a;
  endfunction

  // issue one instruction starting at a negedge; check one negedge later
  task automatic one(input string req, input logic [7:0] op, input logic [63:0] a,
                     input logic [63:0] b, input logic [63:0] exp);
    opcode = op; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, result, exp);
    chk("R2", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R12", {63'd0, out_valid}, 64'd0);
    chk("R12", result, 64'd0);
    chk("R12", {62'd0, not_alu, div_req}, 64'd0);
  endtask

  task automatic t_addsub;
    one("R3", 8'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    one("R3", 8'd13, 64'd40, 64'd2, 64'd42);
    one("R3", 8'd21, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    one("R4", 8'd14, 64'hAAAA_BBBB_FFFF_FFFF, 64'h1234_0000_0000_0002, 64'd1);
    one("R4", 8'd41, 64'h0000_0005_0000_0000, 64'd1, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_logic;
    one("R5", 8'd64,  64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_1234_5678, 64'hF0F0_F0F0_1234_5678);
    one("R4", 8'd82,  64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_1234_5678, 64'h0000_0000_1234_5678);
    one("R4", 8'd96,  64'hFFFF_0000_0000_0001, 64'd2, 64'd3);
    one("R5", 8'd95,  64'hFF00_0000_0000_0000, 64'h0000_0000_0000_00FF, 64'hFF00_0000_0000_00FF);
    one("R5", 8'd115, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 64'h00FF_FF00_00FF_FF00);
    one("R4", 8'd116, 64'hFFFF_FFFF_0000_FFFF, 64'hFFFF_FFFF_FFFF_0000, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_mul;
    one("R6", 8'd42, 64'h1_0000_0001, 64'h1_0000_0001, 64'h0000_0002_0000_0001);
    one("R6", 8'd50, 64'hDEAD_FFFF_FFFF, 64'h1_FFFF_FFFF, 64'hFFFF_FFFE_0000_0001);
    one("R6", 8'd54, 64'hDEAD_FFFF_FFFF, 64'h1_FFFF_FFFF, 64'd1);
    one("R6", 8'd57, 64'h0000_0000_FFFF_FFFE, 64'd3, 64'hFFFF_FFFF_FFFF_FFFA);
    one("R7", 8'd46, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);
    one("R7", 8'd58, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    one("R7", 8'd61, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_shift;
    one("R8", 8'd122, 64'd1, 64'h1_0000_0043, 64'd8);
    one("R8", 8'd128, 64'd1, 64'd4, 64'd16);
    one("R8", 8'd129, 64'h8000_0000_0000_0000, 64'd63, 64'd1);
    one("R8", 8'd133, 64'h8000_0000_0000_0000, 64'd63, 64'hFFFF_FFFF_FFFF_FFFF);
    one("R8", 8'd135, 64'h1234_5678_9ABC_DEF0, 64'hFFC0, 64'h1234_5678_9ABC_DEF0);
    one("R9", 8'd136, 64'h8000_0000_0000_0001, 64'd1, 64'd3);
    one("R9", 8'd157, 64'h8000_0000_0000_0001, 64'h41, 64'hC000_0000_0000_0000);
    one("R9", 8'd146, 64'h0123_4567_89AB_CDEF, 64'd0, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_pass;
    one("R10", 8'd62, 64'h1234, 64'd7, 64'h1234);
    chk("R10", {62'd0, div_req, not_alu}, 64'd2);
    one("R10", 8'd63, 64'hABCD, 64'd0, 64'hABCD);
    chk("R10", {62'd0, div_req, not_alu}, 64'd2);
    one("R11", 8'd158, 64'h5555, 64'd1, 64'h5555);
    chk("R11", {62'd0, div_req, not_alu}, 64'd1);
    one("R11", 8'd255, 64'h7777, 64'd1, 64'h7777);
    chk("R11", {62'd0, div_req, not_alu}, 64'd1);
    one("R11", 8'd0, 64'd1, 64'd1, 64'd2);
    chk("R11", {62'd0, div_req, not_alu}, 64'd0);
  endtask

  task automatic t_stream;
    logic [7:0]  ops[8]  = '{8'd46, 8'd62, 8'd200, 8'd133, 8'd77, 8'd59, 8'd150, 8'd30};
    logic [63:0] as[8]   = '{64'hDEAD_BEEF_0123_4567, 64'h99, 64'h42, 64'h8000_0000_0000_1000,
                             64'hFFFF_FFFF_F0F0_F0F0, 64'h8000_0000_0000_0000, 64'h0F, 64'd5};
    logic [63:0] bs[8]   = '{64'hCAFE_F00D_8765_4321, 64'd3, 64'd9, 64'd12,
                             64'h0000_0000_FF00_FF00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd4, 64'd9};
    for (int i = 0; i < 8; i++) begin
      opcode = ops[i]; op_a = as[i]; op_b = bs[i]; in_valid = 1'b1;
      @(negedge clk);
      chk("R1", result, ref_c(ops[i], as[i], bs[i]));
      chk("R2", {63'd0, out_valid}, 64'd1);
      chk("R1", {62'd0, div_req, not_alu},
          {62'd0, (ops[i] == 8'd62 || ops[i] == 8'd63), (ops[i] > 8'd157)});
    end
    in_valid = 1'b0;
    opcode = 8'd0; op_a = 64'd1; op_b = 64'd1;
  endtask

  task automatic t_idle;
    logic [63:0] held;
    one("R12", 8'd210, 64'h3C3C, 64'd0, 64'h3C3C);
    held = result;
    opcode = 8'd0; op_a = 64'd77; op_b = 64'd88;
    @(negedge clk);
    @(negedge clk);
    chk("R12", result, held);
    chk("R12", {61'd0, out_valid, not_alu, div_req}, 64'd0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_addsub();
    t_logic();
    t_mul();
    t_shift();
    t_pass();
    t_stream();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule